// File: doc/BRIEF.md
# Fan Startup and Spin-Up Sequencer

This block sets the drive level of each fan in a group as power comes up. While reset is held it reads two three-level board straps. One strap picks the startup drive code (off, three quarters or full). The other picks whether the fans get a spin-up kick and how long that kick may last. When reset is released, every fan starts at the startup code. If spin-up is enabled, each fan is instead held at full-scale drive until its tachometer has shown two rising edges or its time limit has run out. Control then returns to the fan's programmed drive code.

A fan whose limit runs out before the second tachometer edge is marked as failed. The mark stays set until the next reset, and any marked fan pulls a shared active-low fail pin low. Software or a controller loop can replace a fan's programmed code at any time through a small write stream. The stream's ready is always high, so no write is ever back-pressured. A write made during spin-up is stored, but it only reaches the drive output once that fan's spin-up ends. The limit is counted in ticks of an external timebase strobe; with a 32.768 kHz tick the defaults give 0.5 s and 1 s.

Top module: `fan_spinup_top`

## Requirements
- R1: The startup drive code is taken from the drive strap: code 2'b00 gives 0, 2'b01 gives 383, and 2'b10 or 2'b11 gives 511. Every fan's programmed code starts at this value after reset.
- R2: With spin strap 2'b00, spin-up is off, and each drive output shows the startup code from the first cycle after reset.
- R3: With spin strap 2'b10 or 2'b11, each fan's drive is 511 until that fan's spin-up ends, and spin-up ends no later than LONG_TICKS timebase ticks after reset.
- R4: With spin strap 2'b01, the limit is SHORT_TICKS ticks instead of LONG_TICKS.
- R5: A fan's spin-up ends on the second rising edge seen on its synchronized tachometer input. A single edge does not end it. An end by tachometer does not set the fail flag.
- R6: When the limit expires first, that fan's spin_fail_o bit is set and stays set until reset, fail_n_o goes low, and the drive returns to the programmed code.
- R7: The spin-up timer advances only in cycles where tick_i is high.
- R8: Straps are sampled only while rst_n is low. Later strap changes have no effect.
- R9: wr_ready_o is always 1. A write with wr_valid_i high replaces the programmed code of fan wr_fan_i only. If that fan is not spinning up, the new code appears on its drive output in the next cycle. During spin-up the code is held and shown once spin-up ends.
- R10: Once a fan's spin-up has ended, it never restarts. Later tachometer edges do not change that fan's drive or fail flag.
- R11: Each fan is sequenced independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| tach_i | input | NFANS | Asynchronous tachometer inputs, one per fan |
| strap_drv_i | input | 2 | Startup drive strap (00 low, 01 open, 1x high) |
| strap_spin_i | input | 2 | Spin-up strap (00 off, 01 short limit, 1x long limit) |
| wr_valid_i | input | 1 | Programmed-code write valid |
| wr_ready_o | output | 1 | Write ready, constant 1 |
| wr_fan_i | input | FANW | Fan index of the write |
| wr_code_i | input | DW | New programmed drive code |
| drive_o | output | NFANS*DW | Drive codes; fan i occupies bits i*DW +: DW |
| spin_fail_o | output | NFANS | Sticky per-fan spin-up failure flags |
| fail_n_o | output | 1 | Active-low: low while any fail flag is set |

## Verification
The hardest state to reach from the ports is a mixed group. In it, some fans have left spin-up through their tachometers, while another fan is still held at full scale with a pending programmed write, and that fan later times out. The stimulus starts spin-up with the long strap setting and sends two tachometer pulses to one fan only. It then writes a new code to a fan that is still spinning and lets the limit run out. After that it pulses the timed-out fan's tachometer to show that it neither restarts nor clears its flag. Holding tick_i low for many cycles separates clock time from timebase time.

// File: rtl/fan_spinup_pkg.sv
package fan_spinup_pkg;
  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_OPEN = 2'b01,
    STRAP_HIGH = 2'b10,
    STRAP_HI2  = 2'b11
  } strap_t;

  // Startup code for a strap level; full is all ones, open is three quarters.
  function automatic logic [8:0] startup_code(input logic [1:0] s);
    case (s)
      2'b00:   startup_code = 9'd0;
      2'b01:   startup_code = 9'd383;
      default: startup_code = 9'd511;
    endcase
  endfunction
endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  logic s0_q, s1_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_q   <= 1'b0;
      s1_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s0_q   <= tach_i;
      s1_q   <= s0_q;
      prev_q <= s1_q;
    end
  end

  assign rise_o = s1_q & ~prev_q;

  // R5: an edge is reported for one cycle only
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fan_seq.sv
module fan_seq #(
  parameter int DW    = 9,
  parameter int TMRW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            rise_i,
  input  logic            spin_en_i,
  input  logic [TMRW-1:0] limit_i,
  input  logic [DW-1:0]   start_code_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_code_i,
  output logic [DW-1:0]   drive_o,
  output logic            fail_o
);
  localparam logic [DW-1:0] FULL = {DW{1'b1}};

  logic [DW-1:0]   prog_q;
  logic [TMRW-1:0] timer_q;
  logic            spinning_q, edge_seen_q, fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q      <= start_code_i;
      timer_q     <= '0;
      spinning_q  <= spin_en_i;
      edge_seen_q <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      if (wr_en_i) prog_q <= wr_code_i;
      if (spinning_q) begin
        if (rise_i && edge_seen_q) begin
          spinning_q <= 1'b0;
        end else begin
          if (rise_i) edge_seen_q <= 1'b1;
          if (tick_i) begin
            if (timer_q == limit_i - 1'b1) begin
              spinning_q <= 1'b0;
              fail_q     <= 1'b1;
            end else begin
              timer_q <= timer_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign drive_o = spinning_q ? FULL : prog_q;
  assign fail_o  = fail_q;

  // R6: failure flag is sticky
  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> fail_q);
  // R10: spin-up never restarts
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !spinning_q |=> !spinning_q);
  // R3: timer stays below the limit
  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q < limit_i);
  // R6: a fail only appears as spin-up ends
  assert_fail_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $fell(spinning_q));
  // R7: timer moves only on a tick
  assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(timer_q));
endmodule

// File: rtl/fan_spinup_top.sv
module fan_spinup_top #(
  parameter int NFANS       = 4,
  parameter int DW          = 9,
  parameter int SHORT_TICKS = 16384,
  parameter int LONG_TICKS  = 32768,
  localparam int FANW = (NFANS > 1) ? $clog2(NFANS) : 1,
  localparam int TMRW = $clog2(LONG_TICKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [NFANS-1:0]    tach_i,
  input  logic [1:0]          strap_drv_i,
  input  logic [1:0]          strap_spin_i,
  input  logic                wr_valid_i,
  output logic                wr_ready_o,
  input  logic [FANW-1:0]     wr_fan_i,
  input  logic [DW-1:0]       wr_code_i,
  output logic [NFANS*DW-1:0] drive_o,
  output logic [NFANS-1:0]    spin_fail_o,
  output logic                fail_n_o
);
  import fan_spinup_pkg::*;

  logic [1:0] drv_q, spin_q, drv_sel, spin_sel;
  logic [DW-1:0]   start_code;
  logic [TMRW-1:0] limit;
  logic            spin_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q  <= strap_drv_i;
      spin_q <= strap_spin_i;
    end
  end

  assign drv_sel    = rst_n ? drv_q  : strap_drv_i;
  assign spin_sel   = rst_n ? spin_q : strap_spin_i;
  assign start_code = DW'(startup_code(drv_sel));
  assign spin_en    = (spin_sel != STRAP_LOW);
  assign limit      = (spin_sel == STRAP_OPEN) ? TMRW'(SHORT_TICKS) : TMRW'(LONG_TICKS);
  assign wr_ready_o = 1'b1;

  for (genvar i = 0; i < NFANS; i++) begin : g_fan
    logic rise;
    fan_tach_sync u_sync (
      .clk(clk), .rst_n(rst_n), .tach_i(tach_i[i]), .rise_o(rise)
    );
    fan_seq #(.DW(DW), .TMRW(TMRW)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rise_i(rise),
      .spin_en_i(spin_en), .limit_i(limit), .start_code_i(start_code),
      .wr_en_i(wr_valid_i && (wr_fan_i == FANW'(i))), .wr_code_i(wr_code_i),
      .drive_o(drive_o[i*DW +: DW]), .fail_o(spin_fail_o[i])
    );
  end

  assign fail_n_o = ~|spin_fail_o;

  // R8: sampled straps hold after reset
  assert_strap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(drv_q) && $stable(spin_q)));
endmodule

// File: tb/sim_fan_spinup_top.sv
module sim_fan_spinup_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4, DW = 9, SHORT = 40, LONG = 80;

  logic clk = 0, rst_n = 0, tick = 1, wr_valid = 0;
  logic [NF-1:0] tach = '0;
  logic [1:0] sdrv = 0, sspin = 0;
  logic [1:0] wr_fan = 0;
  logic [DW-1:0] wr_code = 0;
  logic wr_ready, fail_n;
  logic [NF*DW-1:0] drive;
  logic [NF-1:0] sfail;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_spinup_top #(.NFANS(NF), .DW(DW), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tach_i(tach),
    .strap_drv_i(sdrv), .strap_spin_i(sspin), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .wr_fan_i(wr_fan), .wr_code_i(wr_code),
    .drive_o(drive), .spin_fail_o(sfail), .fail_n_o(fail_n));

  // {drive strap, spin strap, expected startup code}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 2'b00, 9'd0},   {2'b01, 2'b00, 9'd383}, {2'b10, 2'b00, 9'd511},
    {2'b11, 2'b00, 9'd511}, {2'b01, 2'b01, 9'd383}, {2'b00, 2'b11, 9'd0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] d, input logic [1:0] s);
    @(negedge clk);
    rst_n = 0; sdrv = d; sspin = s;
    cyc(3);
    rst_n = 1;
  endtask

  task automatic pulse(input int f);
    tach[f] = 1; cyc(3);
    tach[f] = 0; cyc(3);
  endtask

  task automatic write(input int f, input int code);
    wr_valid = 1; wr_fan = 2'(f); wr_code = DW'(code);
    cyc(1);
    wr_valid = 0;
  endtask

  function automatic int drv(input int f);
    return int'(drive[f*DW +: DW]);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table: startup code per strap, spin-up shows full scale (R1, R2, R3, R4)
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][12:11], VEC[v][10:9]);
      cyc(1);
      for (int f = 0; f < NF; f++)
        chk((VEC[v][10:9] == 2'b00) ? "R1/R2 startup" : "R3/R4 spin full",
            drv(f), (VEC[v][10:9] == 2'b00) ? int'(VEC[v][8:0]) : 511);
      chk("R6 fail clear after reset", int'(fail_n), 1);
    end

    // R8: strap change after reset ignored
    do_reset(2'b01, 2'b00);
    sdrv = 2'b10; sspin = 2'b10;
    cyc(5);
    chk("R8 strap ignored", drv(0), 383);
    chk("R8 strap ignored fail", int'(fail_n), 1);

    // R9: write outside spin-up, selected fan only
    chk("R9 ready", int'(wr_ready), 1);
    write(2, 100);
    chk("R9 written fan", drv(2), 100);
    chk("R9 other fan", drv(1), 383);

    // R3, R5, R6, R9, R10, R11: mixed group with long limit
    do_reset(2'b00, 2'b10);
    pulse(0); pulse(0);
    cyc(2);
    chk("R5 tach end", drv(0), 0);
    chk("R11 other still spinning", drv(1), 511);
    write(1, 200);
    chk("R9 write held in spin", drv(1), 511);
    cyc(55);
    chk("R3 before long limit", drv(1), 511);
    chk("R3 no fail yet", int'(fail_n), 1);
    cyc(20);
    chk("R9 held write shown", drv(1), 200);
    chk("R6 timeout drive", drv(2), 0);
    chk("R6/R5 fail flags", int'(sfail), 4'b1110);
    chk("R6 fail pin", int'(fail_n), 0);
    pulse(1); pulse(1); pulse(0);
    cyc(2);
    chk("R10 no restart", drv(1), 200);
    chk("R10 fail kept", int'(sfail), 4'b1110);

    // R4, R5: short limit, one edge is not enough
    do_reset(2'b01, 2'b01);
    cyc(1);
    chk("R6 cleared by reset", int'(sfail), 0);
    pulse(3);
    cyc(27);
    chk("R5 single edge", drv(3), 511);
    chk("R4 before short limit", drv(0), 511);
    cyc(10);
    chk("R4 short limit", drv(0), 383);
    chk("R4 fail all", int'(sfail), 4'b1111);

    // R7: no ticks, no progress
    tick = 0;
    do_reset(2'b01, 2'b01);
    cyc(100);
    chk("R7 frozen drive", drv(0), 511);
    chk("R7 frozen fail", int'(sfail), 0);
    tick = 1;
    cyc(45);
    chk("R7 resumes", drv(0), 383);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule